// File: doc/BRIEF.md
# Two-Channel Oscillator-Clocked PWM Generator

This block drives two output pads, each from its own pair of generators. The first generator in each pair is a numerically controlled oscillator. It is a phase accumulator that adds an increment derived from a 16-bit control word on every reference clock, and it emits one tick each time the accumulator carries out. The second generator is an 8-bit on/period counter. It advances only on those ticks, so the oscillator acts as its programmable clock divider. A per-channel select bit chooses which generator reaches the pad: the pulse train from the counter, or the oscillator's square wave. For the square wave, the pad takes the accumulator's top bit.

Software programs the block through a plain write strobe with a byte address and data, and reads it back through a combinational data bus. Each channel has four control bits: run, output disable, force high, and open-drain. The output stage can drive the pad push-pull, or it can only pull the pad low. New on and period values are held in a shadow stage and take effect at the next period boundary, so a running waveform never changes in the middle of a cycle.

Top module: `pwm_nco_pair`

## Requirements
- R1: Register map (byte addresses, channel n in {0,1}): control at 0x00, select at 0x04, control-word high byte at 0x08+8n, control-word low byte at 0x0C+8n, on count at 0x18+8n, period count at 0x1C+8n. Every register reads back the value last written to it. The select register holds the select bit of channel n at bit 4n.
- R2: When the control word has bit 15 set, the oscillator increment is the 16-bit two's complement of the word. Otherwise the increment is the word itself. Example: a word of 0xC000 gives the same tick rate as 0x4000.
- R3: With select bit = 1, the pad waveform repeats every (period+1) oscillator ticks and is high for `on` ticks of each repetition. An oscillator tick occurs once per accumulator carry, that is, at a rate of increment/65536 of the clock.
- R4: When on > period, the pulse output stays high without a break. When on = 0, it stays low.
- R5: With select bit = 0, the pad carries the accumulator's most significant bit. For a power-of-two increment this is a 50% square wave of period 65536/increment clocks.
- R6: A channel's control field sits at bits 4n+3..4n: bit 0 run, bit 1 output disable, bit 2 force high, bit 3 open-drain. While run is 0, the accumulator and counter are held at zero and the generated level is 0.
- R7: Force high makes the output level 1 regardless of run and select.
- R8: While output disable is 1, the channel's pad enable is 0.
- R9: In open-drain mode the pad data is always 0. The pad enable is 1 only while the level is 0 and output disable is clear. In push-pull mode the pad data equals the level.
- R10: A write to on or period while the channel runs leaves the current repetition unchanged. The new values apply from the next repetition.
- R11: After reset, every channel's control field is 0b0010 (output disabled), all other registers are 0, and all pad data and enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 8 | Byte address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pad_out | output | 2 | Pad data value, one bit per channel |
| pad_oe | output | 2 | Pad output enable, one bit per channel |

## Verification
The bench sets the control word to 0xC000, 0xE000 and 0xF000. A design that skips the two's-complement fold for these words ticks irregularly and measures the wrong period. It also checks on = 0xFF against period = 0xFE, and on = 0. A design that compares the wrong way would produce one-tick glitches in an output that should stay high or stay low. The bench rewrites the on value in the middle of a high phase. A design without the shadow stage stretches that pulse instead of finishing it at the old length. Open-drain with force high, and open-drain with a running channel, show whether the enable follows the inverted level and whether the pad data is ever allowed to be 1.

// File: rtl/pwm_nco_pkg.sv
package pwm_nco_pkg;

   localparam int CH_FIELD_W  = 4;
   localparam int CH_STRIDE   = 8;
   localparam int ADDR_CTRL   = 8'h00;
   localparam int ADDR_SEL    = 8'h04;

   // per-channel control field, bit 0 first: run, oe_n, force_hi, od
   typedef struct packed {
      logic od;
      logic force_hi;
      logic oe_n;
      logic run;
   } ch_ctrl_t;

   function automatic int cw_hi_addr(int n);
      return 8'h08 + CH_STRIDE * n;
   endfunction

   function automatic int cw_lo_addr(int n);
      return 8'h0C + CH_STRIDE * n;
   endfunction

   function automatic int on_addr(int n);
      return 8'h18 + CH_STRIDE * n;
   endfunction

   function automatic int per_addr(int n);
      return 8'h1C + CH_STRIDE * n;
   endfunction

endpackage

// File: rtl/pwm_nco_osc.sv
module pwm_nco_osc #(
   parameter int ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [ACC_W-1:0] cword,
   output logic             tick,
   output logic             square
);

   logic [ACC_W-1:0] incr;
   logic [ACC_W-1:0] acc_q;
   logic             tick_q;
   logic [ACC_W:0]   sum;

   // fold words above half scale back to their two's complement
   always_comb begin
      if (cword[ACC_W-1])
         incr = ~cword + 1'b1;
      else
         incr = cword;
      sum = {1'b0, acc_q} + {1'b0, incr};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else if (!run) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         acc_q  <= sum[ACC_W-1:0];
         tick_q <= sum[ACC_W];
      end
   end

   assign tick   = tick_q;
   assign square = run & acc_q[ACC_W-1];

   // R6: idle channel keeps its phase at zero
   assert_osc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (acc_q == '0 && !tick_q));

   // R2: folded increment never exceeds half scale, so carries never come back to back
   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |=> !tick_q);

endmodule

// File: rtl/pwm_nco_cfgen.sv
module pwm_nco_cfgen #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] on_new,
   input  logic [CNT_W-1:0] per_new,
   output logic             pwm_hi
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] on_act;
   logic [CNT_W-1:0] per_act;
   logic             wrap;

   assign wrap = tick && (cnt_q == per_act);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         on_act  <= '0;
         per_act <= '0;
      end else if (!run) begin
         cnt_q   <= '0;
         on_act  <= on_new;
         per_act <= per_new;
      end else if (tick) begin
         if (wrap) begin
            cnt_q   <= '0;
            on_act  <= on_new;
            per_act <= per_new;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign pwm_hi = run && (cnt_q < on_act);

   // R3: the phase counter stays inside the active period
   assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= per_act);

   // R10: shadow values only move at a period boundary or while idle
   assert_shadow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap) |=> ($stable(on_act) && $stable(per_act)));

   // R4: on beyond period gives an unbroken high level
   assert_full_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && on_act > per_act) |-> pwm_hi);

endmodule

// File: rtl/pwm_nco_pad.sv
module pwm_nco_pad
   import pwm_nco_pkg::*;
(
   input  ch_ctrl_t cfg,
   input  logic     sel_pwm,
   input  logic     pwm_hi,
   input  logic     square,
   output logic     pad_out,
   output logic     pad_oe
);

   logic level;

   always_comb begin
      if (cfg.force_hi)
         level = 1'b1;
      else if (sel_pwm)
         level = pwm_hi;
      else
         level = square;

      if (cfg.od) begin
         pad_out = 1'b0;
         pad_oe  = !cfg.oe_n && !level;
      end else begin
         pad_out = level;
         pad_oe  = !cfg.oe_n;
      end
   end

endmodule

// File: rtl/pwm_nco_pair.sv
module pwm_nco_pair
   import pwm_nco_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ACC_W  = 16,
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NUM_CH-1:0] pad_out,
   output logic [NUM_CH-1:0] pad_oe
);

   localparam int CTRL_W = CH_FIELD_W * NUM_CH;
   localparam logic [CH_FIELD_W-1:0] CTRL_RST_FIELD = 4'b0010;

   if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
      $error("pwm_nco_pair: NUM_CH must be 1 or 2 for this address map");
   end
   if (ACC_W != 16) begin : g_bad_acc
      $error("pwm_nco_pair: control word is written as two bytes, ACC_W must be 16");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("pwm_nco_pair: CNT_W must lie in 1..8");
   end
   if (ADDR_W < 8 || DATA_W < 8 || DATA_W < CTRL_W) begin : g_bad_bus
      $error("pwm_nco_pair: address and data must be at least one byte wide");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [NUM_CH-1:0] sel_q;
   logic [ACC_W-1:0]  cw_v  [NUM_CH];
   logic [CNT_W-1:0]  on_v  [NUM_CH];
   logic [CNT_W-1:0]  per_v [NUM_CH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= {NUM_CH{CTRL_RST_FIELD}};
         sel_q  <= '0;
      end else if (reg_wr) begin
         if (reg_addr == ADDR_W'(ADDR_CTRL))
            ctrl_q <= reg_wdata[CTRL_W-1:0];
         if (reg_addr == ADDR_W'(ADDR_SEL))
            for (int n = 0; n < NUM_CH; n++)
               sel_q[n] <= reg_wdata[CH_FIELD_W*n];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADDR_CTRL))
         reg_rdata[CTRL_W-1:0] = ctrl_q;
      if (reg_addr == ADDR_W'(ADDR_SEL))
         for (int n = 0; n < NUM_CH; n++)
            reg_rdata[CH_FIELD_W*n] = sel_q[n];
      for (int n = 0; n < NUM_CH; n++) begin
         if (reg_addr == ADDR_W'(cw_hi_addr(n)))
            reg_rdata[7:0] = cw_v[n][ACC_W-1:8];
         if (reg_addr == ADDR_W'(cw_lo_addr(n)))
            reg_rdata[7:0] = cw_v[n][7:0];
         if (reg_addr == ADDR_W'(on_addr(n)))
            reg_rdata[CNT_W-1:0] = on_v[n];
         if (reg_addr == ADDR_W'(per_addr(n)))
            reg_rdata[CNT_W-1:0] = per_v[n];
      end
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      localparam int A_HI  = cw_hi_addr(n);
      localparam int A_LO  = cw_lo_addr(n);
      localparam int A_ON  = on_addr(n);
      localparam int A_PER = per_addr(n);

      logic [ACC_W-1:0] cw_q;
      logic [CNT_W-1:0] on_q;
      logic [CNT_W-1:0] per_q;
      ch_ctrl_t         cfg;
      logic             tick;
      logic             square;
      logic             pwm_hi;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cw_q  <= '0;
            on_q  <= '0;
            per_q <= '0;
         end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(A_HI))
               cw_q[ACC_W-1:8] <= reg_wdata[7:0];
            if (reg_addr == ADDR_W'(A_LO))
               cw_q[7:0] <= reg_wdata[7:0];
            if (reg_addr == ADDR_W'(A_ON))
               on_q <= reg_wdata[CNT_W-1:0];
            if (reg_addr == ADDR_W'(A_PER))
               per_q <= reg_wdata[CNT_W-1:0];
         end
      end

      assign cw_v[n]  = cw_q;
      assign on_v[n]  = on_q;
      assign per_v[n] = per_q;
      assign cfg      = ch_ctrl_t'(ctrl_q[CH_FIELD_W*n +: CH_FIELD_W]);

      pwm_nco_osc #(.ACC_W(ACC_W)) u_osc (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (cfg.run),
         .cword  (cw_q),
         .tick   (tick),
         .square (square)
      );

      pwm_nco_cfgen #(.CNT_W(CNT_W)) u_cfgen (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (cfg.run),
         .tick    (tick),
         .on_new  (on_q),
         .per_new (per_q),
         .pwm_hi  (pwm_hi)
      );

      pwm_nco_pad u_pad (
         .cfg     (cfg),
         .sel_pwm (sel_q[n]),
         .pwm_hi  (pwm_hi),
         .square  (square),
         .pad_out (pad_out[n]),
         .pad_oe  (pad_oe[n])
      );

      // R8: a disabled output never enables its pad
      assert_oe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
         cfg.oe_n |-> !pad_oe[n]);

      // R7: forced level reaches a push-pull pad
      assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg.force_hi && !cfg.od) |-> pad_out[n]);

      // R9: an open-drain pad never drives a one
      assert_od_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
         cfg.od |-> !pad_out[n]);

      // R6: an idle, unforced channel shows a low level
      assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg.run && !cfg.force_hi && !cfg.od) |-> !pad_out[n]);
   end

endmodule

// File: tb/pwm_nco_pair_test.sv
module pwm_nco_pair_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [1:0] pad_out;
   logic [1:0] pad_oe;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;

   always #2 clk = ~clk;

   pwm_nco_pair uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe)
   );

   typedef struct packed {
      logic        ch;
      logic [15:0] cw;
      logic [7:0]  on;
      logic [7:0]  per;
      logic        sel;
      logic [15:0] exp_p;
      logic [15:0] exp_h;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 16'h8000, 8'd3,   8'd7,   1'b1, 16'd16,  16'd6},
      '{1'b0, 16'h4000, 8'd1,   8'd3,   1'b1, 16'd16,  16'd4},
      '{1'b1, 16'hC000, 8'd5,   8'd9,   1'b1, 16'd40,  16'd20},
      '{1'b1, 16'hF000, 8'd2,   8'd4,   1'b1, 16'd80,  16'd32},
      '{1'b0, 16'h2000, 8'd0,   8'd0,   1'b0, 16'd8,   16'd4},
      '{1'b1, 16'hE000, 8'd0,   8'd0,   1'b0, 16'd8,   16'd4},
      '{1'b0, 16'h8000, 8'hFF,  8'hFF,  1'b1, 16'd512, 16'd510}
   };

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_now(logic [7:0] a, logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      wr_now(a, d);
   endtask

   task automatic rd(logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_rise(int ch, output bit ok);
      bit prev;
      ok = 0;
      prev = pad_out[ch];
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (!prev && pad_out[ch]) begin
            ok = 1;
            break;
         end
         prev = pad_out[ch];
      end
   endtask

   task automatic measure(int ch, output int plen, output int hlen);
      bit ok;
      bit prev;
      plen = 0; hlen = 0;
      wait_rise(ch, ok);
      if (ok) wait_rise(ch, ok);
      if (!ok) return;
      plen = 1; hlen = 1; prev = 1;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (!prev && pad_out[ch]) break;
         plen++;
         if (pad_out[ch]) hlen++;
         prev = pad_out[ch];
      end
   endtask

   task automatic count_high(int ch, int n, output int hi, output int oe);
      hi = 0; oe = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pad_out[ch]) hi++;
         if (pad_oe[ch]) oe++;
      end
   endtask

   task automatic setup_ch0(logic [15:0] cw, logic [7:0] on, logic [7:0] per);
      wr(8'h00, 8'h00);
      wr(8'h08, cw[15:8]);
      wr(8'h0C, cw[7:0]);
      wr(8'h18, on);
      wr(8'h1C, per);
      wr(8'h04, 8'h01);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int p, h, hi, oe;
      bit ok;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state
      chk("R11 pad_oe", pad_oe, 0);
      chk("R11 pad_out", pad_out, 0);
      rd(8'h00, d); chk("R11 ctrl", d, 8'h22);
      rd(8'h04, d); chk("R11 sel", d, 0);
      rd(8'h18, d); chk("R11 on0", d, 0);

      // R1: readback of channel 1 registers and select
      wr(8'h10, 8'hA5); wr(8'h14, 8'h3C); wr(8'h20, 8'h77); wr(8'h24, 8'h99);
      wr(8'h04, 8'h11);
      rd(8'h10, d); chk("R1 cw1 hi", d, 8'hA5);
      rd(8'h14, d); chk("R1 cw1 lo", d, 8'h3C);
      rd(8'h20, d); chk("R1 on1", d, 8'h77);
      rd(8'h24, d); chk("R1 per1", d, 8'h99);
      rd(8'h04, d); chk("R1 sel", d, 8'h11);
      rd(8'h08, d); chk("R1 cw0 hi untouched", d, 0);

      // table walk: R2, R3, R5
      for (int v = 0; v < NV; v++) begin
         int ch;
         int other;
         string req;
         ch = VECS[v].ch;
         other = 1 - ch;
         req = !VECS[v].sel ? "R5" : (VECS[v].cw[15] ? "R2" : "R3");
         wr(8'h00, 8'h00);
         wr(8'(8 + 8 * ch), VECS[v].cw[15:8]);
         wr(8'(12 + 8 * ch), VECS[v].cw[7:0]);
         wr(8'(24 + 8 * ch), VECS[v].on);
         wr(8'(28 + 8 * ch), VECS[v].per);
         wr(8'h04, 8'(VECS[v].sel) << (4 * ch));
         wr(8'h00, 8'(1 << (4 * ch)));
         measure(ch, p, h);
         chk($sformatf("%s vec%0d period", req, v), p, VECS[v].exp_p);
         chk($sformatf("%s vec%0d high", req, v), h, VECS[v].exp_h);
         chk($sformatf("R6 vec%0d idle channel", v), pad_out[other], 0);
      end

      // R4: on above period stays high
      setup_ch0(16'h8000, 8'hFF, 8'hFE);
      wr(8'h00, 8'h01);
      count_high(0, 600, hi, oe);
      chk("R4 full duty highs", hi, 600);

      // R4: on zero stays low
      setup_ch0(16'h8000, 8'h00, 8'h05);
      wr(8'h00, 8'h01);
      count_high(0, 300, hi, oe);
      chk("R4 zero duty highs", hi, 0);

      // R6: not running gives low level with pad enabled
      setup_ch0(16'h8000, 8'h05, 8'h09);
      count_high(0, 200, hi, oe);
      chk("R6 stopped highs", hi, 0);
      chk("R6 stopped oe", oe, 200);

      // R7: force high while stopped
      wr(8'h00, 8'h04);
      @(negedge clk);
      chk("R7 forced out", pad_out[0], 1);
      chk("R7 forced oe", pad_oe[0], 1);

      // R8: output disable
      wr(8'h00, 8'h06);
      @(negedge clk);
      chk("R8 disabled oe", pad_oe[0], 0);
      chk("R8 disabled out", pad_out[0], 1);

      // R9: open-drain with level one, then level zero
      wr(8'h00, 8'h0C);
      @(negedge clk);
      chk("R9 od high out", pad_out[0], 0);
      chk("R9 od high oe", pad_oe[0], 0);
      wr(8'h00, 8'h08);
      @(negedge clk);
      chk("R9 od low out", pad_out[0], 0);
      chk("R9 od low oe", pad_oe[0], 1);

      // R9: open-drain running, enable is inverted level (on 3 of 8 ticks, 2 clocks each)
      setup_ch0(16'h8000, 8'h03, 8'h07);
      wr(8'h00, 8'h09);
      repeat (40) @(negedge clk);
      count_high(0, 160, hi, oe);
      chk("R9 od run out", hi, 0);
      chk("R9 od run oe", oe, 100);

      // R10: mid-period rewrite of on keeps current pulse length
      setup_ch0(16'h8000, 8'h03, 8'h07);
      wr(8'h00, 8'h01);
      wait_rise(0, ok);
      wait_rise(0, ok);
      chk("R10 sync", ok, 1);
      wr_now(8'h18, 8'h06);
      h = 0;
      for (int i = 0; i < 1000; i++) begin
         if (!pad_out[0]) break;
         h++;
         @(negedge clk);
      end
      chk("R10 current pulse", h, 5);
      wait_rise(0, ok);
      h = 0;
      for (int i = 0; i < 1000; i++) begin
         if (!pad_out[0]) break;
         h++;
         @(negedge clk);
      end
      chk("R10 next pulse", h, 12);

      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule